// File: doc/BRIEF.md
# Two-Phase Soft Reset Sequencer

This block converts a press of the console's front-panel reset button into a staged CPU reset. The reset is not immediate. First the block raises a maskable early-warning interrupt on CPU interrupt line 2. Software then has time to finish saving data and to bring the coprocessors to idle. The block next shifts a two-bit reset command out to the cartridge security chip and waits for that chip to answer.

The security chip holds its answer back for a grace period of about half a second. It answers by pulling the acknowledge line low for one bit. When the block accepts that acknowledge, it pulses the CPU non-maskable interrupt for a fixed number of cycles. At the same moment it unlocks the internal boot ROM, so that first-stage boot code can run again. It then returns to idle.

The graphics and audio coprocessors receive no reset from this block. The button input is expected to be debounced already. The acknowledge line is expected to be synchronous to `clk`.

Top module: `soft_reset_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `warn_irq_o`, `nmi_o`, `rom_unlock_o` and `cmd_en_o` are all 0.
- R2: In idle, a rising edge of `btn_i` sampled at a clock edge makes `warn_irq_o` read 1 right after that same edge.
- R3: The command is shifted out starting in the cycle after `warn_irq_o` rises. `cmd_en_o` is high for exactly 2 consecutive cycles. `cmd_d_o` carries the reset code 0b11, most significant bit first. `cmd_en_o` is 0 in every other cycle.
- R4: The acknowledge is a 0 on `ack_n_i`, which idles at 1. Count from the first cycle after the last command bit, calling it cycle 0. A low level is accepted only in cycles numbered `GRACE_CYCLES` or later, and only while the block is waiting. Earlier low levels are ignored. When an acknowledge is accepted, `nmi_o` reads 1 after the next edge.
- R5: `nmi_o` stays high for exactly `NMI_WIDTH` cycles. `warn_irq_o` falls in the same cycle that `nmi_o` rises.
- R6: `rom_unlock_o` rises together with `nmi_o`. It then stays 1 until `rst`.
- R7: Button edges arriving from the warning onward, up to the end of the NMI pulse, are ignored. A button held high across the return to idle does not start a new sequence.
- R8: Without an acknowledge, the block keeps waiting indefinitely. `warn_irq_o` stays high and `nmi_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_i | input | 1 | Debounced reset button, 1 = pressed |
| ack_n_i | input | 1 | Acknowledge line from the security chip, 0 = acknowledge |
| warn_irq_o | output | 1 | Early-warning interrupt to CPU line 2 |
| cmd_en_o | output | 1 | Command bit valid strobe |
| cmd_d_o | output | 1 | Serial command bit |
| nmi_o | output | 1 | CPU non-maskable interrupt pulse |
| rom_unlock_o | output | 1 | Boot ROM unlock |

## Verification
The hardest case to reach from the ports is an acknowledge that arrives too early. The acknowledge line goes low while the grace count is still running and rises again before the count completes, and the block must ignore it. The bench drives such a short low pulse straight after the last command bit. It waits well past the grace period and confirms that no NMI appears. It then acknowledges late and measures a one-cycle latency. The table cases place the acknowledge just before, exactly at, and after the grace boundary, so the exact accept cycle is pinned down.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WARN,
    ST_SEND,
    ST_WAIT,
    ST_NMI
  } srs_state_t;

  localparam int CMD_BITS = 2;
  localparam logic [CMD_BITS-1:0] CMD_RESET = 2'b11;
endpackage

// File: rtl/srs_press_detect.sv
module srs_press_detect (
  input  logic clk,
  input  logic rst,
  input  logic btn_i,
  output logic press_o
);
  logic btn_prev;

  always_ff @(posedge clk) begin
    if (rst) btn_prev <= 1'b0;
    else     btn_prev <= btn_i;
  end

  assign press_o = btn_i & ~btn_prev;
endmodule

// File: rtl/srs_cmd_shift.sv
module srs_cmd_shift #(
  parameter int W = 2,
  parameter logic [W-1:0] CODE = '1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic ser_en_o,
  output logic ser_d_o,
  output logic last_o
);
  localparam int LW = $clog2(W + 1);

  logic [W-1:0]  sh;
  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      left <= '0;
    end else if (start_i) begin
      sh   <= CODE;
      left <= LW'(W);
    end else if (left != '0) begin
      sh   <= sh << 1;
      left <= left - 1'b1;
    end
  end

  assign ser_en_o = (left != '0);
  assign ser_d_o  = sh[W-1];
  assign last_o   = (left == LW'(1));
endmodule

// File: rtl/srs_tick_counter.sv
module srs_tick_counter #(
  parameter int MAX = 16,
  parameter int CW  = $clog2(MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] TOP = CW'(MAX);

  always_ff @(posedge clk) begin
    if (rst || clr_i)               cnt_o <= '0;
    else if (en_i && cnt_o != TOP)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/soft_reset_seq.sv
module soft_reset_seq #(
  parameter int GRACE_CYCLES = 25_000_000,
  parameter int NMI_WIDTH    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_i,
  input  logic ack_n_i,
  output logic warn_irq_o,
  output logic cmd_en_o,
  output logic cmd_d_o,
  output logic nmi_o,
  output logic rom_unlock_o
);
  import srs_pkg::*;

  localparam int TMAX = (GRACE_CYCLES > NMI_WIDTH) ? GRACE_CYCLES : NMI_WIDTH;
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] GRACE_C = CW'(GRACE_CYCLES);
  localparam logic [CW-1:0] NMI_END = CW'(NMI_WIDTH - 1);

  srs_state_t    state;
  logic          press;
  logic          tx_last;
  logic [CW-1:0] cnt;
  logic          accept;
  logic          tmr_clr;
  logic          tmr_en;
  logic          warn_q, nmi_q, unlock_q;

  srs_press_detect u_press (
    .clk     (clk),
    .rst     (rst),
    .btn_i   (btn_i),
    .press_o (press)
  );

  srs_cmd_shift #(.W(CMD_BITS), .CODE(CMD_RESET)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .start_i  (state == ST_WARN),
    .ser_en_o (cmd_en_o),
    .ser_d_o  (cmd_d_o),
    .last_o   (tx_last)
  );

  srs_tick_counter #(.MAX(TMAX), .CW(CW)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .clr_i (tmr_clr),
    .en_i  (tmr_en),
    .cnt_o (cnt)
  );

  assign accept  = (state == ST_WAIT) && (cnt >= GRACE_C) && !ack_n_i;
  assign tmr_clr = ((state == ST_SEND) && tx_last) || accept;
  assign tmr_en  = (state == ST_WAIT) || (state == ST_NMI);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      warn_q   <= 1'b0;
      nmi_q    <= 1'b0;
      unlock_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (press) begin
          state  <= ST_WARN;
          warn_q <= 1'b1;
        end
        ST_WARN: state <= ST_SEND;
        ST_SEND: if (tx_last) state <= ST_WAIT;
        ST_WAIT: if (accept) begin
          state    <= ST_NMI;
          warn_q   <= 1'b0;
          nmi_q    <= 1'b1;
          unlock_q <= 1'b1;
        end
        ST_NMI: if (cnt == NMI_END) begin
          state <= ST_IDLE;
          nmi_q <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign warn_irq_o   = warn_q;
  assign nmi_o        = nmi_q;
  assign rom_unlock_o = unlock_q;
endmodule

// File: rtl/soft_reset_seq_chk.sv
module soft_reset_seq_chk (
  input logic clk,
  input logic rst,
  input logic btn_i,
  input logic ack_n_i,
  input logic warn_irq_o,
  input logic cmd_en_o,
  input logic cmd_d_o,
  input logic nmi_o,
  input logic rom_unlock_o
);
  // R2
  warn_after_press_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(warn_irq_o) |-> $past(btn_i));
  // R3
  cmd_inside_warn_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_en_o |-> (warn_irq_o && cmd_d_o));
  // R4
  nmi_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_o) |-> !$past(ack_n_i));
  // R5
  nmi_excl_warn_chk: assert property (@(posedge clk) disable iff (rst)
    !(nmi_o && warn_irq_o));
  // R6
  unlock_with_nmi_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_o |-> rom_unlock_o);
  // R6
  unlock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    rom_unlock_o |=> rom_unlock_o);
  // R8
  warn_ends_in_nmi_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(warn_irq_o) |-> nmi_o);
endmodule

bind soft_reset_seq soft_reset_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .btn_i        (btn_i),
  .ack_n_i      (ack_n_i),
  .warn_irq_o   (warn_irq_o),
  .cmd_en_o     (cmd_en_o),
  .cmd_d_o      (cmd_d_o),
  .nmi_o        (nmi_o),
  .rom_unlock_o (rom_unlock_o)
);

// File: tb/soft_reset_seq_test.sv
module soft_reset_seq_test;
  localparam int G = 8;
  localparam int W = 3;
  localparam int NCASE = 5;
  localparam int unsigned CASE_GAP  [0:NCASE-1] = '{0, 3, 7, 8, 13};
  localparam bit          CASE_MID  [0:NCASE-1] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam bit          CASE_HOLD [0:NCASE-1] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn = 1'b0;
  logic ack_n = 1'b1;
  logic warn, cmd_en, cmd_d, nmi, unlock;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  soft_reset_seq #(.GRACE_CYCLES(G), .NMI_WIDTH(W)) uut (
    .clk(clk), .rst(rst), .btn_i(btn), .ack_n_i(ack_n),
    .warn_irq_o(warn), .cmd_en_o(cmd_en), .cmd_d_o(cmd_d),
    .nmi_o(nmi), .rom_unlock_o(unlock)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_press(input bit hold);
    btn = 1'b1;
    @(negedge clk);
    chk(warn == 1'b1, "R2 warn after press", warn, 1);
    chk(cmd_en == 1'b0, "R3 no bit during warn cycle", cmd_en, 0);
    if (!hold) btn = 1'b0;
    for (int b = 0; b < 2; b++) begin
      @(negedge clk);
      chk(cmd_en && cmd_d, "R3 command bit is 1", {cmd_en, cmd_d}, 3);
    end
    @(negedge clk);
    chk(cmd_en == 1'b0, "R3 exactly two bits", cmd_en, 0);
  endtask

  task automatic run_seq(input int gap, input bit mid, input bit hold);
    int n;
    int w;
    int exp;
    start_press(hold);
    if (mid) btn = 1'b1;
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      if (!hold) btn = 1'b0;
    end
    ack_n = 1'b0;
    exp = ((gap > G) ? gap : G) + 1 - gap;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!nmi && n < G + 20);
    ack_n = 1'b1;
    chk(n == exp, "R4 ack accept cycle", n, exp);
    chk(warn == 1'b0, "R5 warn drops with nmi", warn, 0);
    chk(unlock == 1'b1, "R6 unlock with nmi", unlock, 1);
    w = 1;
    @(negedge clk);
    while (nmi && w < 50) begin
      w++;
      @(negedge clk);
    end
    chk(w == W, "R5 nmi width", w, W);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(warn == 1'b0, "R7 no restart", warn, 0);
    end
    chk(unlock == 1'b1, "R6 unlock sticky", unlock, 1);
    btn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({warn, nmi, unlock, cmd_en} == 4'b0, "R1 outputs in reset", {warn, nmi, unlock, cmd_en}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({warn, nmi, unlock, cmd_en} == 4'b0, "R1 outputs after reset", {warn, nmi, unlock, cmd_en}, 0);

    for (int c = 0; c < NCASE; c++)
      run_seq(CASE_GAP[c], CASE_MID[c], CASE_HOLD[c]);

    // R4 early ack pulse is ignored, R8 keeps waiting
    start_press(1'b0);
    ack_n = 1'b0;
    repeat (2) @(negedge clk);
    ack_n = 1'b1;
    repeat (G + 4) @(negedge clk);
    chk(nmi == 1'b0, "R4 early ack ignored", nmi, 0);
    chk(warn == 1'b1, "R8 warn held while waiting", warn, 1);
    ack_n = 1'b0;
    @(negedge clk);
    chk(nmi == 1'b1, "R4 late ack one cycle", nmi, 1);
    ack_n = 1'b1;
    repeat (W + 2) @(negedge clk);

    // R8 no ack at all
    start_press(1'b0);
    repeat (3 * G) @(negedge clk);
    chk(warn == 1'b1 && nmi == 1'b0, "R8 waits without ack", {warn, nmi}, 2);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(unlock == 1'b0, "R6 unlock cleared by reset", unlock, 0);
    chk({warn, nmi} == 2'b0, "R1 reset mid-wait", {warn, nmi}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule